// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a pixel clock into the three raster strobes a video pipeline needs: vertical sync, horizontal sync and data enable. No porch or sync width is built in. Every interval is a count of pixel clocks taken from an input, and each strobe is a train of pulses. The train has its own start offset, its own high and low lengths and its own pulse count. This lets one block produce standard rasters and odd test timings alike. Along with data enable it gives a pixel index and a line index, so downstream logic can address the active area without counters of its own.

The generator runs freely. The frame origin is the first rising clock edge at which `en` is sampled high while the block is idle, and a new origin follows every frame period after that. The frame period is the vertical-sync offset plus its high length plus its low length. All count inputs are captured only at an origin. Every strobe is registered, so in the requirements below the origin edge is counted as edge 0 and a strobe "after edge j" means the cycle that follows edge j. For a pulse train with offset D, high length H, low length L and count N, pulse k (from 0 up to N-1) is high after edges D+k(H+L) through D+k(H+L)+H-1. For a 1920x1080 raster with a 2200-clock line, the settings are: a vertical-sync offset of 0, a high length of 11000 and a low length of 2464000; a horizontal-sync offset of 0 with 44/2156/1125; and a data-enable offset of 90392 with 1920/280/1080.

Top module: `vtg_top`

## Requirements
- R1: When `rst` is high or `en` is low at a clock edge, `vs_o`, `hs_o`, `de_o`, `pix_x` and `line_y` are all 0 after that edge, and the next edge with `en` high starts a new frame origin.
- R2: Successive frame origins are exactly `vs_dly + max(vs_on,1) + max(vs_off,1)` clocks apart, with no gap.
- R3: Vertical sync is high after edges `vs_dly` through `vs_dly + max(vs_on,1) - 1`, and low for the rest of the frame.
- R4: Horizontal sync is a pulse train with offset `vs_dly + hs_dly` (measured from the vertical-sync offset), high length `max(hs_on,1)`, low length `max(hs_off,1)` and `hs_reps` pulses, and is low after the last pulse.
- R5: Data enable is a pulse train with offset `de_dly` measured from the frame origin, high length `max(de_on,1)`, low length `max(de_off,1)` and `de_reps` pulses.
- R6: A high or low length of zero behaves exactly as a length of one clock.
- R7: A change on any count input between two origins has no effect on the strobes until the next origin.
- R8: While `de_o` is high, `pix_x` is the clock position inside the current data-enable pulse (0 on its first clock). While `de_o` is low, `pix_x` is 0.
- R9: While `de_o` is high, `line_y` is the number of the current data-enable pulse in the frame (0 for the first). While `de_o` is low, `line_y` is 0.
- R10: A new origin cuts off any horizontal-sync or data-enable train that is still running, and the new frame's trains start from their offsets.
- R11: A pulse count of zero produces no pulse on that strobe for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds all outputs at 0 |
| vs_dly | input | LW | Vertical-sync offset from origin, clocks |
| vs_on | input | LW | Vertical-sync high length, clocks |
| vs_off | input | LW | Vertical-sync low length, clocks |
| hs_dly | input | LW | Horizontal-sync offset after the vertical-sync offset |
| hs_on | input | SW | Horizontal-sync high length |
| hs_off | input | SW | Horizontal-sync low length |
| hs_reps | input | SW | Horizontal-sync pulses per frame |
| de_dly | input | LW | Data-enable offset from origin |
| de_on | input | SW | Data-enable high length |
| de_off | input | SW | Data-enable low length |
| de_reps | input | SW | Data-enable pulses per frame |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| pix_x | output | SW | Pixel index within the active pulse |
| line_y | output | SW | Active line index within the frame |

## Verification
The assertions assume that the reset is applied on the first clock and that the count inputs stay below their field widths. The index assertions also assume that two data-enable pulses are never adjacent, and the low length of at least one clock guarantees this. The stimulus changes inputs only mid-cycle, well away from both clock edges. It uses small counts so that several whole frames, cut-off trains and mid-frame setting changes fit into a short run. A cycle-by-cycle reference in the bench keeps its own snapshot of the settings at each origin, so late setting changes are checked against the values that should still apply.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ON   = 2'd2,
        PH_OFF  = 2'd3
    } phase_e;
endpackage

// File: rtl/vtg_frame_clock.sv
module vtg_frame_clock #(
    parameter int LW = 24,
    localparam int FW = LW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [LW-1:0] vs_dly,
    input  logic [LW-1:0] vs_on,
    input  logic [LW-1:0] vs_off,
    output logic          origin
);
    typedef struct packed {
        logic          run;
        logic [FW-1:0] left;
    } fc_t;

    fc_t s_d, s_q;
    logic [FW-1:0] total;

    always_comb begin
        total  = FW'(vs_dly) + FW'((vs_on == '0) ? LW'(1) : vs_on)
               + FW'((vs_off == '0) ? LW'(1) : vs_off);
        origin = en && (!s_q.run || s_q.left == '0);
        s_d    = s_q;
        if (!en) begin
            s_d = '0;
        end else if (origin) begin
            s_d.run  = 1'b1;
            s_d.left = total - 1'b1;
        end else begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R2: between origins the frame countdown steps by exactly one
    assert_frame_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && s_q.run && !origin) |=> (s_q.left == $past(s_q.left) - 1'b1));
endmodule

// File: rtl/vtg_pulse_train.sv
module vtg_pulse_train
    import vtg_pkg::*;
#(
    parameter int DW = 24,
    parameter int HW = 16,
    parameter int NW = 16,
    localparam int CW = (DW > HW) ? DW : HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          start,
    input  logic [DW-1:0] dly,
    input  logic [HW-1:0] on_len,
    input  logic [HW-1:0] off_len,
    input  logic [NW-1:0] reps,
    output logic          strobe,
    output logic [HW-1:0] pos,
    output logic [NW-1:0] run_idx
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [NW-1:0] rep;
        logic [DW-1:0] dly_m;
        logic [HW-1:0] on_m;
        logic [HW-1:0] off_m;
        logic [NW-1:0] reps_m;
    } pt_t;

    pt_t s_d, s_q;
    logic [CW-1:0] lim;
    logic          last;
    logic [NW-1:0] rep_nx;

    always_comb begin
        case (s_q.ph)
            PH_WAIT: lim = CW'(s_q.dly_m);
            PH_ON:   lim = CW'(s_q.on_m);
            default: lim = CW'(s_q.off_m);
        endcase
        last   = (s_q.cnt == lim - 1'b1);
        rep_nx = s_q.rep + 1'b1;
        s_d    = s_q;
        if (clr) begin
            s_d = '0;
        end else if (start) begin
            s_d.cnt    = '0;
            s_d.rep    = '0;
            s_d.dly_m  = dly;
            s_d.on_m   = (on_len == '0) ? HW'(1) : on_len;
            s_d.off_m  = (off_len == '0) ? HW'(1) : off_len;
            s_d.reps_m = reps;
            if (reps == '0)     s_d.ph = PH_IDLE;
            else if (dly == '0) s_d.ph = PH_ON;
            else                s_d.ph = PH_WAIT;
        end else begin
            case (s_q.ph)
                PH_WAIT: begin
                    if (last) begin s_d.ph = PH_ON; s_d.cnt = '0; end
                    else s_d.cnt = s_q.cnt + 1'b1;
                end
                PH_ON: begin
                    if (last) begin s_d.ph = PH_OFF; s_d.cnt = '0; end
                    else s_d.cnt = s_q.cnt + 1'b1;
                end
                PH_OFF: begin
                    if (last) begin
                        s_d.cnt = '0;
                        s_d.rep = rep_nx;
                        s_d.ph  = (rep_nx == s_q.reps_m) ? PH_IDLE : PH_ON;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
        strobe  = (s_q.ph == PH_ON);
        pos     = strobe ? s_q.cnt[HW-1:0] : '0;
        run_idx = strobe ? s_q.rep : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R6: an active train never runs with a zero-length phase
    assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph != PH_IDLE) |-> (s_q.on_m != '0 && s_q.off_m != '0));
    // R4: the position counter stays inside the high phase
    assert_on_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_ON) |-> (s_q.cnt < CW'(s_q.on_m)));
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
    parameter int LW = 24,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [LW-1:0] vs_dly,
    input  logic [LW-1:0] vs_on,
    input  logic [LW-1:0] vs_off,
    input  logic [LW-1:0] hs_dly,
    input  logic [SW-1:0] hs_on,
    input  logic [SW-1:0] hs_off,
    input  logic [SW-1:0] hs_reps,
    input  logic [LW-1:0] de_dly,
    input  logic [SW-1:0] de_on,
    input  logic [SW-1:0] de_off,
    input  logic [SW-1:0] de_reps,
    output logic          vs_o,
    output logic          hs_o,
    output logic          de_o,
    output logic [SW-1:0] pix_x,
    output logic [SW-1:0] line_y
);
    localparam int HDW = LW + 1;

    logic           origin;
    logic           clr;
    logic [HDW-1:0] hs_abs_dly;
    logic [LW-1:0]  vs_pos;
    logic [0:0]     vs_idx;
    logic [SW-1:0]  hs_pos;
    logic [SW-1:0]  hs_idx;

    assign clr        = !en;
    assign hs_abs_dly = HDW'(vs_dly) + HDW'(hs_dly);

    vtg_frame_clock #(.LW(LW)) u_frame (
        .clk(clk), .rst(rst), .en(en),
        .vs_dly(vs_dly), .vs_on(vs_on), .vs_off(vs_off),
        .origin(origin)
    );

    vtg_pulse_train #(.DW(LW), .HW(LW), .NW(1)) u_vs (
        .clk(clk), .rst(rst), .clr(clr), .start(origin),
        .dly(vs_dly), .on_len(vs_on), .off_len(vs_off), .reps(1'b1),
        .strobe(vs_o), .pos(vs_pos), .run_idx(vs_idx)
    );

    vtg_pulse_train #(.DW(HDW), .HW(SW), .NW(SW)) u_hs (
        .clk(clk), .rst(rst), .clr(clr), .start(origin),
        .dly(hs_abs_dly), .on_len(hs_on), .off_len(hs_off), .reps(hs_reps),
        .strobe(hs_o), .pos(hs_pos), .run_idx(hs_idx)
    );

    vtg_pulse_train #(.DW(LW), .HW(SW), .NW(SW)) u_de (
        .clk(clk), .rst(rst), .clr(clr), .start(origin),
        .dly(de_dly), .on_len(de_on), .off_len(de_off), .reps(de_reps),
        .strobe(de_o), .pos(pix_x), .run_idx(line_y)
    );

    // R1: a low enable leaves every strobe low one edge later
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!vs_o && !hs_o && !de_o && pix_x == '0 && line_y == '0));
    // R8: pixel index advances by one inside an active run
    assert_pix_step_R8: assert property (@(posedge clk) disable iff (rst)
        (de_o && $past(de_o) && !$past(origin)) |-> (pix_x == SW'($past(pix_x) + 1'b1)));
    // R9: line index holds for the whole active run
    assert_line_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (de_o && $past(de_o) && !$past(origin)) |-> $stable(line_y));
    // R3: indices of the sync trains read zero whenever their strobe is low
    assert_sync_idx_R3: assert property (@(posedge clk) disable iff (rst)
        (!vs_o |-> (vs_pos == '0 && vs_idx == '0)) and (!hs_o |-> (hs_pos == '0 && hs_idx == '0)));
endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
    localparam int LW = 24;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [LW-1:0] vs_dly = '0, vs_on = '0, vs_off = '0, hs_dly = '0, de_dly = '0;
    logic [SW-1:0] hs_on = '0, hs_off = '0, hs_reps = '0;
    logic [SW-1:0] de_on = '0, de_off = '0, de_reps = '0;
    logic vs_o, hs_o, de_o;
    logic [SW-1:0] pix_x, line_y;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit chk_on = 0;

    // reference model state
    bit m_run = 0;
    int m_p = 0;
    int m_t = 0;
    int vd, vh, vl, hd, hh, hl, hn, dd, dh, dl, dn;

    always #5 clk = ~clk;

    vtg_top #(.LW(LW), .SW(SW)) u_dut (
        .clk(clk), .rst(rst), .en(en),
        .vs_dly(vs_dly), .vs_on(vs_on), .vs_off(vs_off),
        .hs_dly(hs_dly), .hs_on(hs_on), .hs_off(hs_off), .hs_reps(hs_reps),
        .de_dly(de_dly), .de_on(de_on), .de_off(de_off), .de_reps(de_reps),
        .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o), .pix_x(pix_x), .line_y(line_y)
    );

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic unit_exp(input int p, input int d, input int h, input int l, input int n,
                            output bit s, output int pos, output int idx);
        int q, r, w;
        s = 0; pos = 0; idx = 0;
        if (p >= d + 1) begin
            q = p - d - 1;
            r = q / (h + l);
            w = q % (h + l);
            if (r < n && w < h) begin s = 1; pos = w; idx = r; end
        end
    endtask

    task automatic cmp(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", what, tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit es_v, es_h, es_d;
        int pv, iv, ph, ih, pd, id;
        es_v = 0; es_h = 0; es_d = 0; pd = 0; id = 0;
        if (m_run) begin
            unit_exp(m_p, vd, vh, vl, 1, es_v, pv, iv);
            unit_exp(m_p, hd, hh, hl, hn, es_h, ph, ih);
            unit_exp(m_p, dd, dh, dl, dn, es_d, pd, id);
        end
        if (chk_on) begin
            cmp("R3 vs", int'(vs_o), int'(es_v));
            cmp("R4 hs", int'(hs_o), int'(es_h));
            cmp("R5 de", int'(de_o), int'(es_d));
            cmp("R8 pix_x", int'(pix_x), pd);
            cmp("R9 line_y", int'(line_y), id);
        end
        if (rst || !en) begin
            m_run = 0; m_p = 0;
        end else if (!m_run || m_p == m_t) begin
            vd = int'(vs_dly); vh = eff(int'(vs_on)); vl = eff(int'(vs_off));
            hd = vd + int'(hs_dly); hh = eff(int'(hs_on)); hl = eff(int'(hs_off)); hn = int'(hs_reps);
            dd = int'(de_dly); dh = eff(int'(de_on)); dl = eff(int'(de_off)); dn = int'(de_reps);
            m_t = vd + vh + vl;
            m_run = 1; m_p = 1;
        end else begin
            m_p++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic set_cfg(input int a_vd, input int a_vh, input int a_vl,
                           input int a_hd, input int a_hh, input int a_hl, input int a_hn,
                           input int a_dd, input int a_dh, input int a_dl, input int a_dn);
        @(posedge clk); #2;
        vs_dly = LW'(a_vd); vs_on = LW'(a_vh); vs_off = LW'(a_vl);
        hs_dly = LW'(a_hd); hs_on = SW'(a_hh); hs_off = SW'(a_hl); hs_reps = SW'(a_hn);
        de_dly = LW'(a_dd); de_on = SW'(a_dh); de_off = SW'(a_dl); de_reps = SW'(a_dn);
    endtask

    task automatic restart();
        @(posedge clk); #2; en = 0;
        wait_cyc(2);
        en = 1;
    endtask

    task automatic t_reset();
        tag = "R1";
        wait_cyc(3);
        cmp("R1 reset vs", int'(vs_o), 0);
        cmp("R1 reset hs", int'(hs_o), 0);
        cmp("R1 reset de", int'(de_o), 0);
        cmp("R1 reset pix_x", int'(pix_x), 0);
        cmp("R1 reset line_y", int'(line_y), 0);
        rst = 0;
        chk_on = 1;
    endtask

    task automatic t_basic();
        tag = "R3 R4 R5 R8 R9";
        set_cfg(2, 3, 40, 1, 2, 3, 8, 6, 3, 2, 5);
        en = 1;
        wait_cyc(140);
    endtask

    task automatic t_period();
        int gap;
        tag = "R2";
        @(negedge clk);
        while (!(vs_o == 1'b0)) @(negedge clk);
        while (vs_o == 1'b0) @(negedge clk);
        gap = 0;
        @(negedge clk);
        while (vs_o == 1'b1) begin gap++; @(negedge clk); end
        while (vs_o == 1'b0) begin gap++; @(negedge clk); end
        cmp("R2 frame period", gap + 1, 45);
    endtask

    task automatic t_zero_len();
        tag = "R6";
        set_cfg(0, 0, 30, 0, 0, 0, 6, 3, 0, 1, 4);
        restart();
        wait_cyc(70);
    endtask

    task automatic t_mid_change();
        tag = "R7";
        set_cfg(1, 2, 37, 2, 2, 2, 5, 4, 4, 3, 3);
        restart();
        wait_cyc(12);
        set_cfg(5, 6, 30, 0, 1, 1, 9, 1, 2, 1, 6);
        wait_cyc(90);
    endtask

    task automatic t_truncate();
        tag = "R10";
        set_cfg(0, 4, 20, 3, 2, 3, 100, 2, 5, 2, 50);
        restart();
        wait_cyc(80);
    endtask

    task automatic t_zero_reps();
        tag = "R11";
        set_cfg(3, 2, 25, 0, 2, 2, 0, 1, 3, 3, 0);
        restart();
        wait_cyc(60);
    endtask

    task automatic t_enable_drop();
        tag = "R1";
        set_cfg(0, 3, 30, 0, 2, 2, 8, 0, 4, 1, 5);
        restart();
        wait_cyc(9);
        en = 0;
        wait_cyc(1);
        @(negedge clk);
        cmp("R1 en low vs", int'(vs_o), 0);
        cmp("R1 en low hs", int'(hs_o), 0);
        cmp("R1 en low de", int'(de_o), 0);
        cmp("R1 en low pix_x", int'(pix_x), 0);
        wait_cyc(4);
        en = 1;
        wait_cyc(50);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_period();
        t_zero_len();
        t_mid_change();
        t_truncate();
        t_zero_reps();
        t_enable_drop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog [%s] actual=timeout expected=completion", tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule